// File: doc/BRIEF.md
# Two-Channel PWM Controller with Pending-Update Status

This block drives two pulse-width outputs from a small memory-mapped register bus. Each channel has a control register, a clock prescaler, a period length and a duty length. The output period, counted in input clocks, is (prescale+1)×(period+1). The output is high during the first duty×(prescale+1) clocks of each period. Address space for four channels is decoded, but only the first two exist.

Written values do not reach the counters at once. Each write lands in a holding register and raises a sticky pending bit in a shared status word. That bit drops only when the value has been copied into the active registers. With autoload set on a running channel, the copy waits for the end of the current period. Without autoload, it happens on the next clock. Software polls the status word before its next access.

A channel that loses its enable finishes the period it is in before going idle. If the control register also asks for an immediate stop, the channel goes idle at once. The idle level is the inverted level when invert is set.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: After reset all readable registers and the status word read zero and both outputs are low.
- R2: Channel c occupies byte addresses c×16 to c×16+15, with four word registers:
  - control at +0x0, 6 bits: enable bit 0, invert bit 1, autoload bit 2, stop-now bit 3, force-prescale bit 4, force-period bit 5.
  - prescale at +0x4, 10 bits.
  - period at +0x8, 12 bits.
  - duty at +0xC, 12 bits.
  
  Reads return the last written value truncated to these widths.
- R3: The status word is at address 0x40. Channel c uses bits 4c+3:4c, holding pending flags for control (bit 0), prescale (bit 1), period (bit 2) and duty (bit 3). Writes to 0x40, and writes to the unimplemented channel windows 0x20 to 0x3F, change nothing, and those windows read zero.
- R4: A register write sets its pending flag, which reads 1 on the cycle after the write. A control write takes effect and clears its flag one clock later. Without autoload, a prescale, period or duty write also commits and clears its flag one clock later.
- R5: While enabled, the output repeats with a period of (prescale+1)×(period+1) clocks and is high for min(duty, period+1)×(prescale+1) clocks of each period. Duty 0 gives a constantly low output.
- R6: With autoload set on a running channel, pending prescale, period and duty values stay pending, and the output keeps its old shape, until the period ends. They then commit together. On a stopped channel they commit on the next clock.
- R7: With invert set, the running output is the complement of the uninverted waveform, and the idle output is high.
- R8: Clearing enable without stop-now lets the current period run to its end before the output goes idle.
- R9: Clearing enable with stop-now set drives the output to its idle level within two clocks of the control write.
- R10: Force-prescale (or force-period) makes a pending prescale (or period and duty) value commit on the next clock even while autoload is set on a running channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 7 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwm_out | output | 2 | Pulse outputs, one per channel |

## Verification
The hardest state to reach from the ports is a write that lands in the middle of a running period, at a known distance from its end. That is the state needed to show that an autoloaded value stays pending and that a stop waits for the period boundary. The bench finds a period boundary by watching for a rising output edge; with a nonzero duty, that edge marks the first clock of a period. It issues the write on that edge, so the counter phase at every later sample is known exactly. A sweep over small prescale, period and duty values, started from a stopped channel each time, covers the waveform arithmetic. This includes duty values of zero and of one more than the period.

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl #(
  parameter int NCH   = 2,
  parameter int PS_W  = 10,
  parameter int PER_W = 12,
  parameter int AW    = 7,
  parameter int DW    = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int CW = 6;

  logic [4*NCH-1:0]          stat;
  logic [NCH-1:0][3:0][DW-1:0] rv;

  wire is_stat = bus_addr[6] && (bus_addr[5:2] == 4'd0);
  wire unused_ok = ^{bus_addr[1:0], bus_wdata[DW-1:PER_W]};

  for (genvar g = 0; g < NCH; g++) begin : ch
    logic [CW-1:0]    ctrl_q, ctrl_act;
    logic [PS_W-1:0]  ps_hold, ps_act, ps_cnt;
    logic [PER_W-1:0] per_hold, per_act, per_cnt, duty_hold, duty_act;
    logic [3:0]       pend;
    logic             run;

    wire wr_c = bus_wr && !bus_addr[6] && (bus_addr[5:4] == 2'(g));
    wire wr0 = wr_c && bus_addr[3:2] == 2'd0;
    wire wr1 = wr_c && bus_addr[3:2] == 2'd1;
    wire wr2 = wr_c && bus_addr[3:2] == 2'd2;
    wire wr3 = wr_c && bus_addr[3:2] == 2'd3;

    wire en  = ctrl_act[0];
    wire inv = ctrl_act[1];
    wire al  = ctrl_act[2];
    wire stp = ctrl_act[3];

    wire ps_top  = ps_cnt >= ps_act;
    wire per_top = per_cnt >= per_act;
    wire wrap    = run && ps_top && per_top;
    wire c_ps    = !al || ctrl_act[4] || wrap || !run;
    wire c_pd    = !al || ctrl_act[5] || wrap || !run;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q <= '0; ctrl_act <= '0; pend <= '0; run <= 1'b0;
        ps_hold <= '0; ps_act <= '0; ps_cnt <= '0;
        per_hold <= '0; per_act <= '0; per_cnt <= '0;
        duty_hold <= '0; duty_act <= '0;
      end else begin
        if (wr0) ctrl_q <= bus_wdata[CW-1:0];
        ctrl_act <= ctrl_q;
        pend[0]  <= wr0;

        if (wr1) ps_hold <= bus_wdata[PS_W-1:0];
        if (wr2) per_hold <= bus_wdata[PER_W-1:0];
        if (wr3) duty_hold <= bus_wdata[PER_W-1:0];

        if (pend[1] && c_ps) ps_act <= ps_hold;
        if (pend[2] && c_pd) per_act <= per_hold;
        if (pend[3] && c_pd) duty_act <= duty_hold;

        pend[1] <= wr1 || (pend[1] && !c_ps);
        pend[2] <= wr2 || (pend[2] && !c_pd);
        pend[3] <= wr3 || (pend[3] && !c_pd);

        if (!run) begin
          ps_cnt <= '0; per_cnt <= '0;
          run <= en;
        end else if (!en && stp) begin
          ps_cnt <= '0; per_cnt <= '0; run <= 1'b0;
        end else if (ps_top) begin
          ps_cnt <= '0;
          if (per_top) begin
            per_cnt <= '0;
            if (!en) run <= 1'b0;
          end else begin
            per_cnt <= per_cnt + 1'b1;
          end
        end else begin
          ps_cnt <= ps_cnt + 1'b1;
        end
      end
    end

    assign pwm_out[g] = run ? ((per_cnt < duty_act) ^ inv) : inv;
    assign stat[4*g +: 4] = pend;
    assign rv[g][0] = DW'(ctrl_q);
    assign rv[g][1] = DW'(ps_hold);
    assign rv[g][2] = DW'(per_hold);
    assign rv[g][3] = DW'(duty_hold);
  end

  always_comb begin
    bus_rdata = '0;
    if (is_stat) begin
      bus_rdata = DW'(stat);
    end else if (!bus_addr[6]) begin
      for (int c = 0; c < NCH; c++)
        if (bus_addr[5:4] == 2'(c)) bus_rdata = rv[c][bus_addr[3:2]];
    end
  end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [6:0] bus_addr,
  input logic [3:0] pend0,
  input logic [5:0] act0,
  input logic       run0
);
  // R4
  ps_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h04 |=> pend0[1]);

  // R4
  duty_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h0C |=> pend0[3]);

  // R4
  ctrl_pend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend0[0] && !(bus_wr && bus_addr[6:2] == 5'd0) |=> !pend0[0]);

  // R4
  ps_commit_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend0[1] && !act0[2] && !(bus_wr && bus_addr[6:2] == 5'd1) |=> !pend0[1]);

  // R9
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run0 && !act0[0] && act0[3] |=> !run0);
endmodule

bind pwm_pair_ctrl pwm_pair_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .pend0    (ch[0].pend),
  .act0     (ch[0].ctrl_act),
  .run0     (ch[0].run)
);

// File: tb/tb_pwm_pair_ctrl.sv
module tb_pwm_pair_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  pwm_pair_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdr(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(int ch, int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) h++;
    end
  endtask

  task automatic sync_rise(int ch);
    logic prev;
    prev = pwm_out[ch];
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end
  endtask

  task automatic setup0(int ps, int per, int duty, logic [31:0] ctl);
    wr(7'h00, 32'h8); cyc(3);
    wr(7'h04, ps); wr(7'h08, per); wr(7'h0C, duty); cyc(2);
    wr(7'h00, ctl); cyc(3);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    check("R1 out", pwm_out, 0);
    rdr(7'h40, rd); check("R1 status", rd, 0);
    rdr(7'h00, rd); check("R1 ctrl0", rd, 0);
    rdr(7'h1C, rd); check("R1 duty1", rd, 0);

    // R2 readback widths
    wr(7'h04, 32'hFFFF_FFFF); rdr(7'h04, rd); check("R2 prescale width", rd, 32'h3FF);
    wr(7'h18, 32'h0001_FFFF); rdr(7'h18, rd); check("R2 period width", rd, 32'hFFF);
    wr(7'h00, 32'hFF); rdr(7'h00, rd); check("R2 ctrl width", rd, 32'h3F);
    wr(7'h00, 32'h8); cyc(3);

    // R3 / R4 status nibble for channel 1 period
    wr(7'h18, 32'h3); rdr(7'h40, rd); check("R3 ch1 period pending bit6", rd, 32'h40);
    cyc(1); rdr(7'h40, rd); check("R4 pending clears next clock", rd, 0);

    // R3 status and slot-2 writes ignored
    wr(7'h40, 32'hFF); cyc(1); rdr(7'h40, rd); check("R3 status write ignored", rd, 0);
    wr(7'h20, 32'h1); cyc(1); rdr(7'h20, rd); check("R3 slot2 reads zero", rd, 0);
    rdr(7'h40, rd); check("R3 slot2 no status", rd, 0);

    // R5 sweep
    for (int ps = 0; ps < 3; ps++)
      for (int per = 0; per < 4; per++)
        for (int d = 0; d <= per + 1; d++) begin
          int n, e;
          setup0(ps, per, d, 32'h1);
          n = 2 * (ps + 1) * (per + 1);
          e = 2 * ((d < per + 1) ? d : per + 1) * (ps + 1);
          count_high(0, n, h);
          check($sformatf("R5 ps=%0d per=%0d duty=%0d", ps, per, d), h, e);
        end

    // R6 autoload holds duty until period end
    setup0(0, 9, 3, 32'h5);
    sync_rise(0);
    wr(7'h0C, 32'd7);
    rdr(7'h40, rd); check("R6 duty pending after write", rd[3], 1);
    cyc(4); rdr(7'h40, rd); check("R6 duty still pending mid-period", rd[3], 1);
    cyc(10); rdr(7'h40, rd); check("R6 duty committed at wrap", rd[3], 0);
    count_high(0, 20, h); check("R6 new duty shape", h, 14);

    // R6 stopped channel with autoload commits next clock
    wr(7'h00, 32'hC); cyc(3);
    wr(7'h04, 32'd1); cyc(1); rdr(7'h40, rd); check("R6 stopped commit", rd[1], 0);

    // R10 force-period commits immediately under autoload
    setup0(0, 9, 3, 32'h25);
    sync_rise(0);
    wr(7'h0C, 32'd2);
    cyc(1); rdr(7'h40, rd); check("R10 forced duty commit", rd[3], 0);
    count_high(0, 30, h); check("R10 duty shape", h, 6);

    // R8 graceful stop
    setup0(0, 9, 5, 32'h1);
    sync_rise(0);
    wr(7'h00, 32'h0);
    cyc(2); check("R8 period continues", pwm_out[0], 1);
    cyc(15); check("R8 idle after period", pwm_out[0], 0);

    // R9 stop now
    setup0(0, 9, 5, 32'h1);
    sync_rise(0);
    wr(7'h00, 32'h8);
    cyc(2); check("R9 stop immediate", pwm_out[0], 0);

    // R7 invert on channel 1
    wr(7'h10, 32'h8); cyc(3);
    wr(7'h14, 32'd1); wr(7'h18, 32'd3); wr(7'h1C, 32'd1); cyc(2);
    wr(7'h10, 32'h3); cyc(3);
    count_high(1, 16, h); check("R7 inverted high count", h, 12);
    wr(7'h10, 32'hA); cyc(3);
    check("R7 idle level high", pwm_out[1], 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule